// File: doc/BRIEF.md
# Twiddle-Indexed Rounding Complex Multiplier

This combinational block multiplies one signed complex sample by a rotation factor taken from an internal cosine table. The factor is chosen by an index into one full turn of the unit circle. It is meant to sit behind the butterfly of a pipelined FFT stage. The stage's own counter drives the index, and the rotated sample continues down the pipeline in the same cycle.

Samples are 14-bit two's-complement values with 6 integer bits and 8 fraction bits. Rotation factors are 10-bit two's-complement pure fractions, so a full-scale code of 512 stands for 1.0. Only one table is kept, and the sine component is read from the same table a quarter turn further on. The complex product is built from four real multiplies. Each real multiply is rounded back to sample width before the complex sum and difference are formed.

Widths and the table depth are parameters. The table contents are computed during elaboration, and no file is read.

Top module: `twiddle_cmul`

## Requirements
- R1: The rotation factor used for index k has real part T[k] and imaginary part T[(k+16) mod 64], where T is the internal table. With sample (512, 0), the outputs equal (T[k], T[(k+16) mod 64]).
- R2: T[i] = round(512·cos(2π·i/64)), clamped to the range −512..511. In particular T[0] = 511, T[16] = T[48] = 0 and T[32] = −512.
- R3: The real output equals rnd(s_re·w_re) − rnd(s_im·w_im).
- R4: The imaginary output equals rnd(s_im·w_re) + rnd(s_re·w_im).
- R5: rnd(p) of a 24-bit signed product p takes product bits 22 down to 9 and adds 1 when product bit 8 is set (round half up). For example, 256·511 gives 256 and −256·511 gives −255.
- R6: Each of the four products is rounded on its own before the sum or difference. Sample (1, 1) at index 8 therefore gives real output 2 and imaginary output 0.
- R7: The rounded products, and the final sum and difference, wrap modulo 2^14 with no saturation. Sample (−8192, 0) at index 32 gives real output −8192.
- R8: A zero sample gives a zero result at every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_re | input | 14 | Sample real part, signed, 8 fraction bits |
| smp_im | input | 14 | Sample imaginary part, signed, 8 fraction bits |
| tw_idx | input | 6 | Rotation index, one turn spread over 64 steps |
| res_re | output | 14 | Rotated sample real part, same format as input |
| res_im | output | 14 | Rotated sample imaginary part, same format as input |

## Verification
On every input change, the assertions check four things. They check the table anchor points at index 0 and at the half-turn, that a zero sample gives zero out, and that a unit-gain sample passes the selected factor straight through. They also check that whenever one input part is zero, each output lies within half a step of the exact product. Only the bench scenarios can show the finer points: exact round-half-up on the two signs, rounding each product before the combine, the quarter-turn offset across all 64 indices, and wrap on overflow. The bench covers these by comparing against an independent integer model over directed and random samples.

// File: rtl/tw_cmul_pkg.sv
package tw_cmul_pkg;

   localparam real PI_C = 3.14159265358979323846;

   // Cosine by power series; the argument is kept inside [-pi, pi].
   function automatic real series_cos(input real x);
      real acc;
      real term;
      real xx;
      acc  = 1.0;
      term = 1.0;
      xx   = x * x;
      for (int k = 1; k <= 24; k++) begin
         term = -term * xx / real'((2 * k - 1) * (2 * k));
         acc  = acc + term;
      end
      return acc;
   endfunction

   // Signed table code for entry idx of a depth-entry full turn.
   function automatic int cos_code(input int idx, input int depth, input int coef_w);
      real ang;
      real v;
      int  full;
      int  r;
      ang = 2.0 * PI_C * real'(idx) / real'(depth);
      if (ang > PI_C) ang = ang - 2.0 * PI_C;
      full = 1 << (coef_w - 1);
      v    = series_cos(ang) * real'(full);
      if (v >= 0.0) r = $rtoi(v + 0.5);
      else          r = -$rtoi(0.5 - v);
      if (r > full - 1) r = full - 1;
      if (r < -full)    r = -full;
      return r;
   endfunction

endpackage

// File: rtl/tw_cos_rom.sv
module tw_cos_rom #(
   parameter int IDX_W  = 6,
   parameter int COEF_W = 10
) (
   input  logic [IDX_W-1:0]         idx,
   output logic signed [COEF_W-1:0] w_re,
   output logic signed [COEF_W-1:0] w_im
);
   import tw_cmul_pkg::*;

   localparam int DEPTH = 1 << IDX_W;
   localparam logic [IDX_W-1:0] QUAD = IDX_W'(DEPTH / 4);

   if (IDX_W < 2)  $error("tw_cos_rom: IDX_W must be at least 2");
   if (COEF_W < 3) $error("tw_cos_rom: COEF_W must be at least 3");

   logic signed [COEF_W-1:0] tab [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_tab
      localparam int CODE = cos_code(g, DEPTH, COEF_W);
      assign tab[g] = COEF_W'(CODE);
   end

   // Sine component: same table, a quarter turn ahead (wraps in IDX_W bits)
   logic [IDX_W-1:0] idx_im;
   assign idx_im = idx + QUAD;

   assign w_re = tab[idx];
   assign w_im = tab[idx_im];

endmodule

// File: rtl/tw_round_mult.sv
module tw_round_mult #(
   parameter int A_W = 14,
   parameter int B_W = 10
) (
   input  logic signed [A_W-1:0] a,
   input  logic signed [B_W-1:0] b,
   output logic signed [A_W-1:0] r
);
   localparam int P_W   = A_W + B_W;
   localparam int KEEPH = P_W - 2;
   localparam int KEEPL = B_W - 1;
   localparam int RBIT  = B_W - 2;

   if (B_W < 3)   $error("tw_round_mult: B_W must be at least 3");
   if (A_W < B_W) $error("tw_round_mult: A_W must not be below B_W");

   logic signed [P_W-1:0] prod;
   logic [A_W-1:0]        keep;
   logic                  unused_bits;

   assign prod = P_W'(a) * P_W'(b);

   // Drop the redundant sign bit and the fraction of b; round half up.
   assign keep        = prod[KEEPH:KEEPL];
   assign r           = keep + A_W'(prod[RBIT]);
   assign unused_bits = ^{prod[P_W-1], prod[RBIT-1:0]};

endmodule

// File: rtl/twiddle_cmul.sv
module twiddle_cmul #(
   parameter int DATA_W = 14,
   parameter int COEF_W = 10,
   parameter int IDX_W  = 6
) (
   input  logic signed [DATA_W-1:0] smp_re,
   input  logic signed [DATA_W-1:0] smp_im,
   input  logic [IDX_W-1:0]         tw_idx,
   output logic signed [DATA_W-1:0] res_re,
   output logic signed [DATA_W-1:0] res_im
);
   localparam int LANES = 4;

   if (DATA_W < COEF_W) $error("twiddle_cmul: DATA_W must not be below COEF_W");

   logic signed [COEF_W-1:0] w_re;
   logic signed [COEF_W-1:0] w_im;

   tw_cos_rom #(.IDX_W(IDX_W), .COEF_W(COEF_W)) u_rom (
      .idx  (tw_idx),
      .w_re (w_re),
      .w_im (w_im)
   );

   // Lanes: 0 re*re, 1 im*im, 2 im*re, 3 re*im
   logic signed [DATA_W-1:0] lane_a [LANES];
   logic signed [COEF_W-1:0] lane_b [LANES];
   logic signed [DATA_W-1:0] lane_r [LANES];

   assign lane_a[0] = smp_re;
   assign lane_a[1] = smp_im;
   assign lane_a[2] = smp_im;
   assign lane_a[3] = smp_re;
   assign lane_b[0] = w_re;
   assign lane_b[1] = w_im;
   assign lane_b[2] = w_re;
   assign lane_b[3] = w_im;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      tw_round_mult #(.A_W(DATA_W), .B_W(COEF_W)) u_mul (
         .a (lane_a[l]),
         .b (lane_b[l]),
         .r (lane_r[l])
      );
   end

   assign res_re = lane_r[0] - lane_r[1];
   assign res_im = lane_r[2] + lane_r[3];

endmodule

// File: rtl/tw_cmul_chk.sv
module tw_cmul_chk #(
   parameter int DATA_W = 14,
   parameter int COEF_W = 10,
   parameter int IDX_W  = 6
) (
   input logic signed [DATA_W-1:0] smp_re,
   input logic signed [DATA_W-1:0] smp_im,
   input logic [IDX_W-1:0]         tw_idx,
   input logic signed [DATA_W-1:0] res_re,
   input logic signed [DATA_W-1:0] res_im,
   input logic signed [COEF_W-1:0] w_re,
   input logic signed [COEF_W-1:0] w_im
);
   localparam longint SCALE = longint'(1) << (COEF_W - 1);
   localparam longint HALF  = SCALE / 2;
   localparam longint LIM   = ((longint'(1) << (DATA_W - 1)) - 1) * SCALE;
   localparam logic signed [COEF_W-1:0] MAXC   = COEF_W'(SCALE - 1);
   localparam logic signed [COEF_W-1:0] MINC   = COEF_W'(-SCALE);
   localparam logic [IDX_W-1:0]         HALF_I = IDX_W'((1 << IDX_W) / 2);
   localparam logic signed [DATA_W-1:0] UNIT_A = DATA_W'(SCALE);

   function automatic longint mag(input longint v);
      return (v < 0) ? -v : v;
   endfunction

   longint p_rr;
   longint p_ri;
   longint p_qq;

   always_comb begin
      p_rr = longint'(smp_re) * longint'(w_re);
      p_ri = longint'(smp_re) * longint'(w_im);
      p_qq = longint'(smp_im) * longint'(w_im);
      if (!$isunknown({smp_re, smp_im, tw_idx, res_re, res_im, w_re, w_im})) begin
         if (smp_re == '0 && smp_im == '0) begin
            assert_zero_in_R8: assert (res_re == '0 && res_im == '0)
               else $error("zero sample gave nonzero result");
         end
         if (tw_idx == '0) begin
            assert_peak_R2: assert (w_re == MAXC && w_im == '0)
               else $error("table anchor at index 0 wrong");
         end
         if (tw_idx == HALF_I) begin
            assert_trough_R2: assert (w_re == MINC && w_im == '0)
               else $error("table anchor at half turn wrong");
         end
         if (smp_re == UNIT_A && smp_im == '0) begin
            assert_unit_gain_R1: assert (res_re == DATA_W'(w_re) && res_im == DATA_W'(w_im))
               else $error("unit sample did not pass the factor through");
         end
         if (smp_im == '0 && mag(p_rr) < LIM) begin
            assert_round_re_R5: assert ((p_rr - longint'(res_re) * SCALE) >= -HALF &&
                                        (p_rr - longint'(res_re) * SCALE) <= HALF - 1)
               else $error("real result not within half a step");
         end
         if (smp_im == '0 && mag(p_ri) < LIM) begin
            assert_round_im_R4: assert ((p_ri - longint'(res_im) * SCALE) >= -HALF &&
                                        (p_ri - longint'(res_im) * SCALE) <= HALF - 1)
               else $error("imaginary result not within half a step");
         end
         if (smp_re == '0 && mag(p_qq) < LIM) begin
            assert_neg_re_R3: assert ((p_qq + longint'(res_re) * SCALE) >= -HALF &&
                                      (p_qq + longint'(res_re) * SCALE) <= HALF - 1)
               else $error("real result of pure imaginary sample off");
         end
      end
   end

endmodule

bind twiddle_cmul tw_cmul_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W), .IDX_W(IDX_W)) chk_i (
   .smp_re (smp_re),
   .smp_im (smp_im),
   .tw_idx (tw_idx),
   .res_re (res_re),
   .res_im (res_im),
   .w_re   (w_re),
   .w_im   (w_im)
);

// File: tb/twiddle_cmul_tb_top.sv
`timescale 1ns/1ps
module twiddle_cmul_tb_top;

   logic               clk = 1'b0;
   logic signed [13:0] smp_re = '0;
   logic signed [13:0] smp_im = '0;
   logic [5:0]         tw_idx = '0;
   logic signed [13:0] res_re;
   logic signed [13:0] res_im;

   always #10 clk = ~clk;

   twiddle_cmul dut_i (
      .smp_re (smp_re),
      .smp_im (smp_im),
      .tw_idx (tw_idx),
      .res_re (res_re),
      .res_im (res_im)
   );

   typedef struct {
      int    ar;
      int    ai;
      int    idx;
      int    er;
      int    ei;
      string tag;
   } item_t;

   item_t sbq[$];
   int    n_run  = 0;
   int    n_fail = 0;
   int    tab_ref [64];
   bit    done   = 1'b0;

   // Reference: 14-bit wrap, round-half-up by floor((p + 256) / 512)
   function automatic int wrap14(input longint v);
      longint m;
      m = v & 64'h3FFF;
      if (m >= 8192) m = m - 16384;
      return int'(m);
   endfunction

   function automatic int rnd(input longint p);
      return wrap14((p + 256) >>> 9);
   endfunction

   task automatic send_exp(input int ar, input int ai, input int idx,
                           input int er, input int ei, input string tag);
      item_t it;
      @(posedge clk);
      #2;
      smp_re = 14'(ar);
      smp_im = 14'(ai);
      tw_idx = 6'(idx);
      it.ar = ar; it.ai = ai; it.idx = idx; it.er = er; it.ei = ei; it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic send_ref(input int ar, input int ai, input int idx, input string tag);
      int wr;
      int wi;
      wr = tab_ref[idx];
      wi = tab_ref[(idx + 16) % 64];
      send_exp(ar, ai, idx,
               wrap14(longint'(rnd(longint'(ar) * wr)) - longint'(rnd(longint'(ai) * wi))),
               wrap14(longint'(rnd(longint'(ai) * wr)) + longint'(rnd(longint'(ar) * wi))),
               tag);
   endtask

   // Monitor: compares at the falling edge, away from input changes
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         n_run++;
         if (int'(res_re) != it.er || int'(res_im) != it.ei) begin
            n_fail++;
            $display("FAIL %s: in (%0d,%0d) idx %0d got (%0d,%0d) expected (%0d,%0d)",
                     it.tag, it.ar, it.ai, it.idx, res_re, res_im, it.er, it.ei);
         end
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         real v;
         int  c;
         v = 512.0 * $cos(2.0 * 3.14159265358979323846 * real'(i) / 64.0);
         c = $rtoi($floor(v + 0.5));
         if (c > 511) c = 511;
         tab_ref[i] = c;
      end

      // R8: zero sample (also the idle state at start)
      send_exp(0, 0, 5, 0, 0, "R8 zero sample");
      send_exp(0, 0, 63, 0, 0, "R8 zero sample idx 63");
      // R2 / R1 table anchors with unit-gain sample
      send_exp(512, 0, 0, 511, 0, "R2 entry 0 peak");
      send_exp(512, 0, 16, 0, -512, "R2 entry 16 zero, quarter offset R1");
      send_exp(512, 0, 32, -512, 0, "R2 entry 32 trough");
      send_exp(512, 0, 48, 0, 511, "R2 entry 48 zero, offset wraps R1");
      send_exp(512, 0, 8, 362, -362, "R1 index 8");
      // R5 round half up on both signs
      send_exp(256, 0, 0, 256, 0, "R5 positive half rounds up");
      send_exp(-256, 0, 0, -255, 0, "R5 negative half rounds up");
      // R6 per-product rounding before combine
      send_exp(1, 1, 8, 2, 0, "R6 rounding before sum");
      // R7 wrap
      send_exp(-8192, 0, 32, -8192, 0, "R7 product wraps");
      send_exp(8191, -8192, 8, -1, 4801, "R7 sum wraps");

      // R1 / R2 across every index
      for (int k = 0; k < 64; k++) send_ref(512, 0, k, "R1 R2 sweep");
      // R3 pure imaginary sample across every index
      for (int k = 0; k < 64; k++) send_ref(0, 512, k, "R3 imaginary sweep");
      // R3 R4 random samples over all indices
      for (int n = 0; n < 2048; n++) begin
         int ar;
         int ai;
         ar = int'($urandom_range(16383, 0)) - 8192;
         ai = int'($urandom_range(16383, 0)) - 8192;
         send_ref(ar, ai, n % 64, "R3 R4 random");
      end

      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule